// File: doc/BRIEF.md
# Parallel-load serial-out shift register

This block holds a row of stages that can take a whole word at once and then release it one bit at a time from its far end. A level-sensitive, active-low load input makes every stage copy the parallel word for as long as it is held low. While load is released, each rising edge of a derived shift clock moves the word one place toward the last stage, and a serial input fills the first stage. The derived shift clock is the OR of two equivalent clock lines. Holding either line high stops shifting, so one line can serve as an active-low enable for the other.

The block runs on a free-running system clock. The two shift-clock lines, the load line and the serial input are all resynchronised through a short flip-flop chain on that clock. A shift edge is recognised when the resynchronised OR goes from 0 to 1. The last stage is driven out together with its inverse. Longer converters are built by feeding the last-stage output of one instance into the serial input of the next.

Top module: `piso_shift_reg`

## Requirements
- R1: A synchronous active-high reset clears every stage, so `q_last` reads 0 and `q_last_n` reads 1 afterwards.
- R2: While `load_n` is low, the stages continuously follow `par_in`, with bit i going to stage i. Changes to `par_in` during a held load are tracked.
- R3: Load has priority. A rising edge of the derived shift clock while `load_n` is low does not shift.
- R4: While `load_n` is high, each rising edge of (`shclk_a` OR `shclk_b`) moves stage i to stage i+1 and puts `ser_in` into stage 0. After a load of word W and k shifts, `q_last` equals W[STAGES-1-k].
- R5: While either shift-clock line is held high, toggling the other line causes no shift.
- R6: The two shift-clock lines are interchangeable. A rise of `shclk_b` while `shclk_a` is low shifts exactly like a rise of `shclk_a` while `shclk_b` is low.
- R7: Raising `load_n` while both shift-clock lines are low causes no shift. The first shift comes on the next rise of the derived clock.
- R8: `q_last_n` is always the inverse of `q_last`.
- R9: With `q_last` of one instance wired to `ser_in` of a second, and the controls shared, the pair behaves as one register of twice the length.
- R10: A change on a control line takes effect at the (SYNC_DEPTH+1)-th rising system-clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| par_in | input | STAGES | Parallel word, bit i loads stage i |
| load_n | input | 1 | Level-sensitive active-low load |
| ser_in | input | 1 | Serial data into stage 0 |
| shclk_a | input | 1 | Shift-clock line, ORed with shclk_b |
| shclk_b | input | 1 | Shift-clock line, ORed with shclk_a |
| q_last | output | 1 | Last stage |
| q_last_n | output | 1 | Inverse of last stage |

## Verification
The bench builds two instances with the default STAGES=8 and SYNC_DEPTH=2 and chains them into a 16-bit converter. With eight stages, every stage reaches the output within a short burst of shifts. A two-flop synchroniser gives a fixed three-edge latency that the bench can probe one edge at a time. Random sequences of loads, shifts through either clock line, and blocked toggles are compared against a 16-bit reference model. Directed cases cover a rising clock during load, release of load, and latency.

// File: rtl/piso_pkg.sv
package piso_pkg;

    // Sampled control lines of the register
    typedef struct packed {
        logic load_n;
        logic clk_a;
        logic clk_b;
        logic ser;
    } piso_ctrl_t;

    // Reset value: load inactive, shift clock parked high so no edge follows reset
    localparam piso_ctrl_t CTRL_IDLE = '{load_n: 1'b1, clk_a: 1'b1, clk_b: 1'b1, ser: 1'b0};

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } piso_op_e;

    function automatic logic gated_clk(input piso_ctrl_t c);
        return c.clk_a | c.clk_b;
    endfunction

endpackage

// File: rtl/piso_sync.sv
module piso_sync
    import piso_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  piso_ctrl_t raw,
    output piso_ctrl_t synced
);

    piso_ctrl_t pipe [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= CTRL_IDLE;
                else     pipe[g] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= CTRL_IDLE;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    assign synced = pipe[DEPTH-1];

endmodule

// File: rtl/piso_ctl.sv
module piso_ctl
    import piso_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  piso_ctrl_t synced,
    output piso_op_e   op,
    output logic       ser_bit
);

    logic gate_now;
    logic gate_prev;
    logic gate_rise;

    assign gate_now  = gated_clk(synced);
    assign gate_rise = gate_now & ~gate_prev;
    assign ser_bit   = synced.ser;

    always_ff @(posedge clk) begin
        if (rst) gate_prev <= 1'b1;
        else     gate_prev <= gate_now;
    end

    always_comb begin
        if (!synced.load_n)  op = OP_LOAD;
        else if (gate_rise)  op = OP_SHIFT;
        else                 op = OP_HOLD;
    end

endmodule

// File: rtl/piso_stages.sv
module piso_stages
    import piso_pkg::*;
#(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  piso_op_e          op,
    input  logic [STAGES-1:0] par_in,
    input  logic              ser_bit,
    output logic [STAGES-1:0] stage_q
);

    logic [STAGES-1:0] stage_d;

    always_comb begin
        unique case (op)
            OP_LOAD:  stage_d = par_in;
            OP_SHIFT: stage_d = {stage_q[STAGES-2:0], ser_bit};
            default:  stage_d = stage_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
    import piso_pkg::*;
#(
    parameter int STAGES     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] par_in,
    input  logic              load_n,
    input  logic              ser_in,
    input  logic              shclk_a,
    input  logic              shclk_b,
    output logic              q_last,
    output logic              q_last_n
);

    localparam int MSB = STAGES - 1;

    piso_ctrl_t        ctrl_raw;
    piso_ctrl_t        ctrl_sync;
    piso_op_e          op;
    logic              ser_bit;
    logic [STAGES-1:0] stage_q;

    assign ctrl_raw = '{load_n: load_n, clk_a: shclk_a, clk_b: shclk_b, ser: ser_in};

    piso_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (ctrl_raw),
        .synced (ctrl_sync)
    );

    piso_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .synced  (ctrl_sync),
        .op      (op),
        .ser_bit (ser_bit)
    );

    piso_stages #(.STAGES(STAGES)) u_stages (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .par_in  (par_in),
        .ser_bit (ser_bit),
        .stage_q (stage_q)
    );

    assign q_last   = stage_q[MSB];
    assign q_last_n = ~stage_q[MSB];

endmodule

// File: rtl/piso_shift_reg_chk.sv
module piso_shift_reg_chk
    import piso_pkg::*;
#(
    parameter int STAGES = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [STAGES-1:0] par_in,
    input logic              q_last,
    input logic              q_last_n,
    input piso_ctrl_t        ctrl_sync,
    input piso_op_e          op,
    input logic              ser_bit,
    input logic [STAGES-1:0] stage_q
);

    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b1;
        else     gate_q <= ctrl_sync.clk_a | ctrl_sync.clk_b;
    end

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (stage_q == '0)); // R1

    AST_LOAD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD) |=> (stage_q == $past(par_in))); // R2

    AST_LOAD_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        !ctrl_sync.load_n |-> (op == OP_LOAD)); // R3

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |=> (stage_q == {$past(stage_q[STAGES-2:0]), $past(ser_bit)})); // R4

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> $stable(stage_q)); // R4

    AST_BLOCKED_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (gate_q && (ctrl_sync.clk_a | ctrl_sync.clk_b)) |-> (op != OP_SHIFT)); // R5

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        q_last_n == ~q_last); // R8

endmodule

bind piso_shift_reg piso_shift_reg_chk #(.STAGES(STAGES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .par_in    (par_in),
    .q_last    (q_last),
    .q_last_n  (q_last_n),
    .ctrl_sync (ctrl_sync),
    .op        (op),
    .ser_bit   (ser_bit),
    .stage_q   (stage_q)
);

// File: tb/tb_piso_shift_reg.sv
`timescale 1ns/1ps
module tb_piso_shift_reg;

    localparam int N      = 8;
    localparam int SETTLE = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] par_a, par_b;
    logic         load_n, ser, ca, cb;
    logic         qa, qa_n, qb, qb_n;

    logic [N-1:0] ref_a, ref_b;
    int           checks = 0;
    int           errors = 0;
    bit           done   = 0;

    always #2.5 clk = ~clk;

    piso_shift_reg #(.STAGES(N), .SYNC_DEPTH(2)) dut (
        .clk(clk), .rst(rst), .par_in(par_a), .load_n(load_n), .ser_in(ser),
        .shclk_a(ca), .shclk_b(cb), .q_last(qa), .q_last_n(qa_n));

    piso_shift_reg #(.STAGES(N), .SYNC_DEPTH(2)) dut_b (
        .clk(clk), .rst(rst), .par_in(par_b), .load_n(load_n), .ser_in(qa),
        .shclk_a(ca), .shclk_b(cb), .q_last(qb), .q_last_n(qb_n));

    task automatic settle();
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, qa, ref_a[N-1]);
        chk("R8", qa_n, ~ref_a[N-1]);
        chk(req, qb, ref_b[N-1]);
        chk("R8", qb_n, ~ref_b[N-1]);
    endtask

    function automatic logic [2*N-1:0] shifted(input logic [N-1:0] a, input logic [N-1:0] b, input logic s);
        return {b[N-2:0], a[N-1], a[N-2:0], s};
    endfunction

    task automatic model_shift();
        {ref_b, ref_a} = shifted(ref_a, ref_b, ser);
    endtask

    task automatic do_load(input logic [N-1:0] wa, input logic [N-1:0] wb);
        par_a = wa; par_b = wb; load_n = 1'b0;
        settle();
        ref_a = wa; ref_b = wb;
        check_all("R2");
    endtask

    task automatic shift_via(input bit use_b, input logic s);
        ser = s;
        settle();
        if (use_b) cb = 1'b1; else ca = 1'b1;
        settle();
        model_shift();
        check_all(use_b ? "R6" : "R4");
        if (use_b) cb = 1'b0; else ca = 1'b0;
        settle();
        check_all("R4");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; par_a = '0; par_b = '0; load_n = 1'b1; ser = 1'b0; ca = 1'b0; cb = 1'b0;
        ref_a = '0; ref_b = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        settle();
        check_all("R1");

        // R2: follow while held
        do_load(8'hA5, 8'h3C);
        do_load(8'h5A, 8'hC3);
        // R3: rising clock during load does nothing
        ca = 1'b1; settle(); check_all("R3");
        ca = 1'b0; settle(); check_all("R3");
        // R7: release with both clocks low, no shift
        load_n = 1'b1; settle(); check_all("R7");
        shift_via(1'b0, 1'b1);
        check_all("R7");

        // R10: latency probe
        do_load(8'h80, 8'h00);
        load_n = 1'b1; ser = 1'b0; settle();
        ca = 1'b1;
        repeat (2) @(posedge clk);
        #1 chk("R10", qa, 1'b1);
        @(posedge clk);
        #1 chk("R10", qa, 1'b0);
        @(negedge clk);
        model_shift();
        ca = 1'b0; settle(); check_all("R10");

        // R5: one line high blocks the other
        ca = 1'b1; settle(); model_shift(); check_all("R4");
        for (int i = 0; i < 3; i++) begin
            cb = 1'b1; settle(); check_all("R5");
            cb = 1'b0; settle(); check_all("R5");
        end
        ca = 1'b0; settle(); check_all("R5");
        cb = 1'b1; settle();
        for (int i = 0; i < 2; i++) begin
            ca = 1'b1; settle(); check_all("R5");
            ca = 1'b0; settle(); check_all("R5");
        end
        cb = 1'b0; settle(); check_all("R5");

        // R9: full 16-bit cascade drain
        do_load(8'hD2, 8'h69);
        load_n = 1'b1; settle();
        for (int k = 0; k < 2*N; k++) shift_via(k[0], 1'b0);
        chk("R9", qb, 1'b0);

        // Random mix
        for (int it = 0; it < 250; it++) begin
            int sel = $urandom_range(0, 9);
            if (sel == 0) begin
                do_load(N'($urandom), N'($urandom));
                load_n = 1'b1; settle(); check_all("R7");
            end else if (sel < 5) begin
                shift_via(1'b0, 1'($urandom));
            end else if (sel < 9) begin
                shift_via(1'b1, 1'($urandom));
            end else begin
                ca = 1'b1; settle(); model_shift(); check_all("R4");
                cb = 1'b1; settle(); check_all("R5");
                cb = 1'b0; settle(); check_all("R5");
                ca = 1'b0; settle(); check_all("R5");
            end
        end
        chk("R9", qb, ref_b[N-1]);

        // R1 again after traffic
        rst = 1'b1; repeat (3) @(posedge clk); @(negedge clk); rst = 1'b0;
        ref_a = '0; ref_b = '0;
        settle();
        check_all("R1");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule